// File: doc/BRIEF.md
# Piecewise-Linear Code to Temperature Converter

This block turns a raw reading from an on-die temperature sensor's converter into a signed temperature in thousandths of a degree Celsius. It holds a fixed table of breakpoints. The table's codes may rise or fall with temperature, and an input picks which direction applies. For each request the block runs a bisection search for the pair of adjacent breakpoints that enclose the code. It then interpolates linearly between their temperatures, using a shift-add multiplier and a restoring divider that each resolve one bit per clock.

A request is a one-cycle `start` together with the code and the table direction. The block raises `busy` until the answer is ready, then pulses `done` for one cycle. If no breakpoint pair encloses the code, `err` is set with that pulse and the previous result is left in place.

Top module: `pwl_temp_conv`

## Requirements
- R1: Only the low CODE_W (12) bits of `code_in` take part in a conversion; the upper bits of the 16-bit input have no effect on `err` or `result`.
- R2: The table has 34 breakpoints, index k = 0..33, with temperature -40000 + 5000*k. In rising mode (`dec_mode`=0) the code at k is 100 + 24*k + floor(k*k/2). In falling mode (`dec_mode`=1) the code at k is 4000 - 24*k - floor(k*k/2). A code equal to breakpoint k (k >= 1) converts to exactly that breakpoint's temperature.
- R3: In rising mode, the enclosing index k satisfies code(k-1) < code <= code(k). A code is valid exactly when 100 < code <= 1436.
- R4: In falling mode, the enclosing index k satisfies code(k) <= code < code(k-1). A code is valid exactly when 2664 <= code < 4000.
- R5: A valid result equals T(k-1) + floor(5000 * |code(k-1) - code| / |code(k-1) - code(k)|).
- R6: An invalid code gives `err`=1 with the `done` pulse and leaves `result` at its previous value. A valid conversion gives `err`=0.
- R7: `start` is taken only while `busy` is low. `busy` is high from the cycle after an accepted `start` until `done`, and a `start` seen while busy is dropped without producing a later conversion.
- R8: `done` lasts exactly one cycle, and `busy` falls in that same cycle. A valid conversion finishes at most 49 clocks after the accepting edge, and an invalid one at most 7.
- R9: `result` is a two's-complement 32-bit value, so temperatures below zero come out negative.
- R10: After reset, `busy`, `done` and `err` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| dec_mode | input | 1 | 1: table codes fall as temperature rises; 0: they rise |
| code_in | input | 16 | Raw converter reading; masked to 12 bits |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result or error is ready |
| err | output | 1 | The last conversion found no enclosing breakpoints |
| result | output | 32 | Signed temperature in millidegrees |

## Verification
The time to an answer depends on the path the request takes. The search resolves in one to six steps, after which the valid path adds 13 multiply cycles, 29 divide cycles and one cycle to form the result, giving at most 49 clocks. A miss ends the search within seven clocks. Because the search depth varies with the code, the bench does not wait a fixed number of cycles. On the falling edge after each clock it polls for `done`, samples `err` and `result` in the pulse cycle, and checks both that the count of cycles stays within the bound for that path and that `done` is low again one cycle later. Expected values come from a linear scan of the breakpoint formulas inside the bench, so the bench does not share the design's bisection.

// File: rtl/pwl_temp_conv.sv
module pwl_temp_conv #(
  parameter int DIN_W    = 16,
  parameter int CODE_W   = 12,
  parameter int N_PTS    = 34,
  parameter int TEMP0    = -40000,
  parameter int STEP_MC  = 5000,
  parameter int INC_BASE = 100,
  parameter int DEC_TOP  = 4000,
  parameter int SLOPE    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dec_mode,
  input  logic [DIN_W-1:0]   code_in,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic signed [31:0] result
);
  localparam int IDX_W = $clog2(N_PTS + 1);
  localparam int MW    = $clog2(STEP_MC + 1);
  localparam int NUM_W = DIN_W + MW;
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [DIN_W-1:0] MASK = {{(DIN_W-CODE_W){1'b0}}, {CODE_W{1'b1}}};
  localparam logic [MW-1:0] STEP_V = MW'(STEP_MC);

  typedef enum logic [2:0] {S_IDLE, S_SRCH, S_MUL, S_DIV, S_FIN} st_t;

  function automatic logic [DIN_W-1:0] bp_code(input logic dm, input logic [IDX_W-1:0] i);
    int k;
    k = int'(i);
    if (dm) return DIN_W'(DEC_TOP - SLOPE * k - (k * k) / 2);
    return DIN_W'(INC_BASE + SLOPE * k + (k * k) / 2);
  endfunction

  st_t              st;
  logic [DIN_W-1:0] code_q, den_q;
  logic             mode_q;
  logic [IDX_W-1:0] lo, hi, idx, mid;
  logic [NUM_W-1:0] acc, mcand, nq, acc_nx;
  logic [MW-1:0]    mplier;
  logic [CNT_W-1:0] cnt;
  logic [DIN_W:0]   rem, trial;
  logic [DIN_W-1:0] c_lo, c_hi;
  logic             hit, go_up, empty, ge;

  assign mid    = IDX_W'((32'(lo) + 32'(hi)) >> 1);
  assign c_lo   = bp_code(mode_q, mid - IDX_W'(1));
  assign c_hi   = bp_code(mode_q, mid);
  assign hit    = mode_q ? (code_q >= c_hi && code_q < c_lo) : (code_q <= c_hi && code_q > c_lo);
  assign go_up  = mode_q ? (code_q < c_hi) : (code_q > c_hi);
  assign empty  = lo > hi;
  assign acc_nx = acc + (mplier[0] ? mcand : '0);
  assign trial  = {rem[DIN_W-1:0], nq[NUM_W-1]};
  assign ge     = rem[DIN_W] || (trial >= {1'b0, den_q});
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; code_q <= '0; mode_q <= 1'b0; lo <= '0; hi <= '0; idx <= '0;
      den_q <= '0; acc <= '0; mcand <= '0; mplier <= '0; cnt <= '0; nq <= '0;
      rem <= '0; done <= 1'b0; err <= 1'b0; result <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          code_q <= code_in & MASK;
          mode_q <= dec_mode;
          lo     <= IDX_W'(1);
          hi     <= IDX_W'(N_PTS - 1);
          st     <= S_SRCH;
        end
        S_SRCH: begin
          if (empty) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (hit) begin
            idx    <= mid;
            mcand  <= NUM_W'(mode_q ? c_lo - code_q : code_q - c_lo);
            den_q  <= mode_q ? c_lo - c_hi : c_hi - c_lo;
            acc    <= '0;
            mplier <= STEP_V;
            cnt    <= '0;
            st     <= S_MUL;
          end else if (go_up) lo <= mid + IDX_W'(1);
          else hi <= mid - IDX_W'(1);
        end
        S_MUL: begin
          acc    <= acc_nx;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          cnt    <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(MW - 1)) begin
            nq  <= acc_nx;
            rem <= '0;
            cnt <= '0;
            st  <= S_DIV;
          end
        end
        S_DIV: begin
          rem <= ge ? trial - {1'b0, den_q} : trial;
          nq  <= {nq[NUM_W-2:0], ge};
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(NUM_W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          result <= TEMP0 + STEP_MC * (int'(idx) - 1) + int'(nq);
          err    <= 1'b0;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_busy_end_r8:    assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  p_accept_r7:      assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  p_range_r5:       assert property (@(posedge clk) disable iff (!rst_n)
                      (done && !err) |-> (result >= TEMP0 && result <= TEMP0 + STEP_MC * (N_PTS - 1)));
  p_err_hold_r6:    assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> $stable(result));
endmodule

// File: tb/pwl_temp_conv_test.sv
module pwl_temp_conv_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dec_mode = 1'b0;
  logic [15:0] code_in = '0;
  logic busy, done, err;
  logic signed [31:0] result;
  int tests = 0, fails = 0;
  logic signed [31:0] prev_res = 0;

  pwl_temp_conv uut (.clk(clk), .rst_n(rst_n), .start(start), .dec_mode(dec_mode),
    .code_in(code_in), .busy(busy), .done(done), .err(err), .result(result));

  always #10 clk = ~clk;

  function automatic int tc(bit dm, int k);
    return dm ? 4000 - 24 * k - (k * k) / 2 : 100 + 24 * k + (k * k) / 2;
  endfunction

  function automatic bit ref_conv(bit dm, int c, output int r);
    r = 0;
    for (int k = 1; k < 34; k++) begin
      int a = tc(dm, k - 1), b = tc(dm, k);
      if (!dm && c > a && c <= b) begin r = -40000 + 5000 * (k - 1) + (5000 * (c - a)) / (b - a); return 1; end
      if (dm && c >= b && c < a) begin r = -40000 + 5000 * (k - 1) + (5000 * (a - c)) / (a - b); return 1; end
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", what, act, exp); end
  endtask

  task automatic conv(input logic [15:0] cin, input bit dm, output bit e, output int r, output int n);
    @(negedge clk); code_in = cin; dec_mode = dm; start = 1'b1;
    @(negedge clk); start = 1'b0; n = 0;
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    while (!done && n < 200) begin @(negedge clk); n++; end
    e = err; r = result;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 done one cycle, idle after", done, 0);
  endtask

  task automatic one(input logic [15:0] cin, input bit dm, input string tag);
    bit e, ok; int r, n, ex;
    ok = ref_conv(dm, int'(cin[11:0]), ex);
    conv(cin, dm, e, r, n);
    if (ok) begin
      chk(e == 1'b0, {tag, " err low on valid code"}, e, 0);
      chk(r == ex, {tag, " R5 result"}, r, ex);
      chk(n <= 49, "R8 valid latency", n, 49);
      prev_res = r;
    end else begin
      chk(e == 1'b1, {tag, " R6 err on invalid code"}, e, 1);
      chk(r == prev_res, "R6 result held on error", r, prev_res);
      chk(n <= 7, "R8 error latency", n, 7);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit e; int r, n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && result == 0, "R10 reset state", result, 0);

    one(16'd0, 1'b0, "R3 low");     one(16'd100, 1'b0, "R3 first");
    one(16'd101, 1'b0, "R3 edge");  one(16'd612, 1'b0, "R3 mid");
    one(16'd1436, 1'b0, "R3 top");  one(16'd1437, 1'b0, "R3 above");
    one(16'd4095, 1'b0, "R3 max");
    one(16'd4000, 1'b1, "R4 first"); one(16'd3999, 1'b1, "R4 edge");
    one(16'd2664, 1'b1, "R4 last");  one(16'd2663, 1'b1, "R4 below");
    one(16'd0, 1'b1, "R4 zero");

    conv(16'hF000 | 16'd612, 1'b0, e, r, n);
    chk(e == 0 && r == -40000 + 5000 * 16, "R1 upper bits ignored", r, -40000 + 5000 * 16);
    conv(16'hA000 | 16'd1437, 1'b0, e, r, n);
    chk(e == 1, "R1 upper bits do not make code valid", e, 1);

    conv(16'd3999, 1'b1, e, r, n);
    chk(r == -39792, "R9 negative result", r, -39792);

    for (int k = 1; k < 34; k++) begin
      conv(16'(tc(0, k)), 1'b0, e, r, n);
      chk(r == -40000 + 5000 * k, "R2 rising breakpoint exact", r, -40000 + 5000 * k);
      conv(16'(tc(1, k)), 1'b1, e, r, n);
      chk(r == -40000 + 5000 * k, "R2 falling breakpoint exact", r, -40000 + 5000 * k);
    end

    begin
      int ex; bit ok;
      ok = ref_conv(0, 700, ex);
      @(negedge clk); code_in = 16'd700; dec_mode = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      code_in = 16'd3000; dec_mode = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0; n = 0;
      while (!done && n < 200) begin @(negedge clk); n++; end
      chk(ok && err == 0 && result == ex, "R7 start while busy dropped", result, ex);
      prev_res = result;
      n = 0;
      repeat (60) begin @(negedge clk); if (done || busy) n++; end
      chk(n == 0, "R7 no queued conversion", n, 0);
    end

    for (int t = 0; t < 300; t++) begin
      bit dm = 1'($urandom);
      logic [15:0] c;
      case ($urandom % 3)
        0: c = 16'($urandom);
        1: c = {4'($urandom), 12'(101 + $urandom % 1336)};
        default: c = {4'($urandom), 12'(2664 + $urandom % 1336)};
      endcase
      one(c, dm, dm ? "R4 random" : "R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule